// File: doc/BRIEF.md
# Instruction-Boundary Interrupt and Reset Sequencer

This block sits beside the opcode decoder of a cycle-stepped 8-bit processor. At every instruction boundary it chooses between two actions. It either lets the freshly fetched opcode through to the decoder, or it replaces that opcode with the break opcode 0x00 so that an interrupt or a reset runs through the ordinary break micro-sequence. It presents the instruction register as the opcode in the upper bits and a per-instruction cycle count in the low bits. It also drives the opcode-fetch strobe and tells the break sequence which vector to load.

The decoder reports when the current cycle is the final one of an instruction and whether that instruction is a conditional branch. It also supplies the opcode byte on the data bus. The sequencer models the timing quirks that matter to cycle-exact software:

- An interrupt must be visible some cycles before an instruction ends. Otherwise it waits one more instruction.
- Branches use a shorter window.
- An NMI that shows up early in a break started by an IRQ takes over that break's vector.

Cycle numbering used below: the fetch cycle (sync high) is cycle 0 of an instruction, and an instruction of length L ends with cycle L-1. A line value "present at the end of cycle k" means it is sampled by the rising clock edge that closes cycle k.

Top module: `int_sequencer`

## Requirements
- R1: While `res_n` is low, `sync` is 1 and `ir` is 0. The cycle in which `res_n` is released is a fetch cycle that injects a break, so the first 7-cycle sequence runs with `hw_brk` 1 and `vec_sel` 2 (reset). Only after that sequence is an opcode from the bus fetched.
- R2: `ir` is {opcode, count}, with the count in the low `CNT_W` bits. In a fetch cycle the count is 0 and the opcode field shows the bus byte, unless an injection is due. The count is 1 in the next cycle and then rises by one each cycle, holding at 7.
- R3: `sync` is 1 exactly in the cycle after a cycle in which `last_cycle` was 1 while `sync` was 0. `last_cycle` is ignored during a fetch cycle.
- R4: For an instruction that is not a branch, of length L, a request present at the end of cycle L-3 or earlier is serviced at the boundary that follows it.
- R5: For a branch of length L, a request present at the end of cycle L-2 or earlier is serviced at the following boundary.
- R6: A request that misses the window is serviced at the end of the next instruction instead.
- R7: A serviced request replaces the bus opcode with 0x00, and `hw_brk` is 1 in cycles 1 to 6 of that sequence. A 0x00 taken from the bus keeps `hw_brk` at 0 and uses `vec_sel` 0.
- R8: The NMI request is a falling edge on `nmi_n`. Holding the line low produces exactly one service, with `vec_sel` 1.
- R9: The IRQ request is `irq_n` held low while `i_flag` is 0. While `i_flag` is 1 no IRQ is serviced.
- R10: If both requests qualify at the same boundary, NMI wins and `vec_sel` is 1.
- R11: During a break using vector 0, an NMI falling edge sampled at the end of cycle `HIJACK_LAST`-1 or earlier switches `vec_sel` to 1 and consumes that NMI. A later edge leaves `vec_sel` at 0, and the NMI is serviced at a later boundary. `vec_sel` does not change after cycle `HIJACK_LAST`.
- R12: `stack_rd_only` is 1 only in cycles 1 to 6 of the reset sequence, so that its stack writes become reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | Processor reset request, active low, asynchronous assert |
| irq_n | input | 1 | Maskable request, level, active low |
| nmi_n | input | 1 | Non-maskable request, falling edge |
| i_flag | input | 1 | Interrupt-disable flag from the status register |
| last_cycle | input | 1 | Decoder: current cycle is the instruction's final cycle |
| is_branch | input | 1 | Decoder: current instruction is a conditional branch |
| opcode | input | OP_W | Data bus byte carrying the fetched opcode |
| ir | output | OP_W+CNT_W | Instruction register: opcode and cycle count |
| sync | output | 1 | Opcode fetch cycle |
| hw_brk | output | 1 | Current break was injected by hardware |
| vec_sel | output | 2 | Vector: 0 IRQ/BRK, 1 NMI, 2 reset |
| stack_rd_only | output | 1 | Reset sequence active; stack writes turned into reads |

## Verification
The bench builds the block with its default parameters: OP_W 8, CNT_W 3 and HIJACK_LAST 3. With these values the full 7-cycle break fits the counter, and the hijack boundary falls between break cycles 2 and 3. The bench plays the decoder with instruction lengths from 2 to 7, both as branches and as non-branches. It also runs one 10-cycle instruction so that the count reaches its hold value. Random request offsets within each instruction reach both sides of both window edges. A directed sweep of NMI edges across break cycles -1 to 6 covers both sides of the hijack limit.

// File: rtl/int_sequencer.sv
module int_sequencer #(
  parameter int OP_W        = 8,
  parameter int CNT_W       = 3,
  parameter int HIJACK_LAST = 3
) (
  input  logic                  clk,
  input  logic                  res_n,
  input  logic                  irq_n,
  input  logic                  nmi_n,
  input  logic                  i_flag,
  input  logic                  last_cycle,
  input  logic                  is_branch,
  input  logic [OP_W-1:0]       opcode,
  output logic [OP_W+CNT_W-1:0] ir,
  output logic                  sync,
  output logic                  hw_brk,
  output logic [1:0]            vec_sel,
  output logic                  stack_rd_only
);
  localparam int IR_W = OP_W + CNT_W;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] HJ      = CNT_W'(HIJACK_LAST);
  localparam logic [1:0] V_IRQ = 2'd0, V_NMI = 2'd1, V_RST = 2'd2;

  logic [IR_W-1:0] ir_q;
  logic sync_q, rst_pend, hw_q;
  logic nmi_q, nmi_pend, nmi_d2, irq_d1, irq_d2;
  logic take_irq, take_nmi;
  logic [1:0] vsel;

  wire irq_cond = ~irq_n & ~i_flag;
  wire nmi_fall = nmi_q & ~nmi_n;
  wire boundary = last_cycle & ~sync_q;
  wire nmi_now  = is_branch ? nmi_pend : nmi_d2;
  wire irq_now  = is_branch ? irq_d1 : irq_d2;
  wire inject   = rst_pend | take_nmi | take_irq;
  wire [OP_W-1:0]  next_op = inject ? '0 : opcode;
  wire [CNT_W-1:0] cnt     = ir_q[CNT_W-1:0];
  wire in_brk   = ~sync_q & (ir_q[IR_W-1:CNT_W] == '0);
  wire hijack   = in_brk & (vsel == V_IRQ) & nmi_pend & (cnt <= HJ);
  wire nmi_ack  = (sync_q & take_nmi & ~rst_pend) | hijack;

  always_ff @(posedge clk or negedge res_n) begin
    if (!res_n) begin
      ir_q     <= '0;
      sync_q   <= 1'b1;
      rst_pend <= 1'b1;
      hw_q     <= 1'b0;
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
      nmi_d2   <= 1'b0;
      irq_d1   <= 1'b0;
      irq_d2   <= 1'b0;
      take_irq <= 1'b0;
      take_nmi <= 1'b0;
      vsel     <= V_RST;
    end else begin
      nmi_q    <= nmi_n;
      irq_d1   <= irq_cond;
      irq_d2   <= irq_d1;
      nmi_pend <= nmi_fall | (nmi_pend & ~nmi_ack);
      nmi_d2   <= nmi_pend & ~nmi_ack;
      sync_q   <= boundary;
      if (boundary) begin
        take_nmi <= nmi_now;
        take_irq <= irq_now;
      end
      if (sync_q) begin
        ir_q     <= {next_op, CNT_ONE};
        hw_q     <= inject;
        rst_pend <= 1'b0;
        take_nmi <= 1'b0;
        take_irq <= 1'b0;
        if (next_op == '0)
          vsel <= rst_pend ? V_RST : (take_nmi ? V_NMI : V_IRQ);
      end else begin
        if (cnt != CNT_MAX) ir_q[CNT_W-1:0] <= cnt + CNT_ONE;
        if (hijack) vsel <= V_NMI;
      end
    end
  end

  assign ir            = sync_q ? {next_op, {CNT_W{1'b0}}} : ir_q;
  assign sync          = sync_q;
  assign hw_brk        = hw_q & ~sync_q;
  assign vec_sel       = vsel;
  assign stack_rd_only = in_brk & (vsel == V_RST);

  a_r3_sync_follows_last: assert property (@(posedge clk) disable iff (!res_n)
    (last_cycle && !sync) |=> (sync && ir[CNT_W-1:0] == '0));

  a_r2_count_starts_at_one: assert property (@(posedge clk) disable iff (!res_n)
    sync |=> (sync || ir[CNT_W-1:0] == CNT_ONE));

  a_r7_hw_only_on_break: assert property (@(posedge clk) disable iff (!res_n)
    hw_brk |-> (ir[IR_W-1:CNT_W] == '0));

  a_r12_rd_only_in_reset: assert property (@(posedge clk) disable iff (!res_n)
    stack_rd_only |-> (hw_brk && vec_sel == V_RST));

  a_r11_vector_locked: assert property (@(posedge clk) disable iff (!res_n)
    (!sync && ir[CNT_W-1:0] > HJ) |=> $stable(vec_sel));
endmodule

// File: tb/int_sequencer_bench.sv
`timescale 1ns/1ps
module int_sequencer_bench;
  logic clk = 1'b0;
  logic res_n = 1'b0, irq_n = 1'b1, nmi_n = 1'b1, i_flag = 1'b0;
  logic last_cycle = 1'b0, is_branch = 1'b0;
  logic [7:0] opcode = 8'hEA;
  logic [10:0] ir;
  logic sync, hw_brk, stack_rd_only;
  logic [1:0] vec_sel;

  int_sequencer u_int_sequencer (
    .clk(clk), .res_n(res_n), .irq_n(irq_n), .nmi_n(nmi_n), .i_flag(i_flag),
    .last_cycle(last_cycle), .is_branch(is_branch), .opcode(opcode),
    .ir(ir), .sync(sync), .hw_brk(hw_brk), .vec_sel(vec_sel),
    .stack_rd_only(stack_rd_only)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int gcyc = 0, k = 0, cur_len = 2, len_next = 2;
  bit cur_br = 0, br_next = 0, lc_drv = 0, sync_seen = 0;
  logic [7:0] cur_op = 8'hEA, obs_op;
  logic [10:0] obs_ir;
  int irq_at = -1, nmi_at = -1, nmi_w = 1;
  int brk_cnt = 0, nmi_svc = 0;

  function automatic bit exp_taken(int len, bit br, int j);
    return j <= len - 3 + int'(br);
  endfunction

  function automatic bit exp_hijack(int h);
    return h <= 2;
  endfunction

  function automatic bit exp_nmi_after(int h);
    return h >= 3 && h <= 4;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, gcyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    gcyc++;
    sync_seen = sync;
    obs_ir = ir;
    obs_op = opcode;
    if (sync) begin
      cur_op = ir[10:3];
      k = 0;
      cur_len = (cur_op == 8'h00) ? 7 : len_next;
      cur_br = (cur_op == 8'h00) ? 1'b0 : br_next;
      if (cur_op == 8'h00 && res_n) brk_cnt++;
    end else k++;
    if (!sync && cur_op == 8'h00 && k == 1 && hw_brk) irq_at = -1;
    if (!sync && cur_op == 8'h00 && k == 6 && vec_sel == 2'd1) nmi_svc++;
    lc_drv = (k == cur_len - 1);
    last_cycle = lc_drv;
    is_branch = cur_br;
    irq_n = !(irq_at >= 0 && gcyc >= irq_at);
    nmi_n = !(nmi_at >= 0 && gcyc >= nmi_at && gcyc < nmi_at + nmi_w);
    if (k == 1) opcode = 8'h01 + 8'($urandom % 255);
  endtask

  task automatic to_boundary();
    do tick(); while (!lc_drv);
  endtask

  task automatic wait_sync();
    do tick(); while (!sync_seen);
  endtask

  task automatic settle();
    len_next = 2; br_next = 0;
    repeat (30) tick();
    irq_at = -1; nmi_at = -1; nmi_w = 1; i_flag = 1'b0;
  endtask

  task automatic window(input bit use_nmi, input int len, input bit br, input int j);
    int a0;
    bit ex;
    settle();
    to_boundary();
    len_next = len; br_next = br;
    a0 = gcyc + 1;
    if (use_nmi) begin nmi_at = a0 + j; nmi_w = 1; end
    else irq_at = a0 + j;
    tick();
    len_next = 2; br_next = 0;
    wait_sync();
    ex = exp_taken(len, br, j);
    if (ex) chk(obs_ir == 11'd0, br ? "R5 branch window taken" : "R4 window taken", obs_ir, 0);
    else begin
      chk(obs_ir == {obs_op, 3'b000}, br ? "R5 branch window deferred" : "R4 window deferred",
          obs_ir, {obs_op, 3'b000});
      wait_sync();
      chk(obs_ir == 11'd0, "R6 serviced one instruction later", obs_ir, 0);
    end
    if (use_nmi && ex) begin
      tick();
      chk(vec_sel == 2'd1, "R8 nmi vector", vec_sel, 1);
    end
  endtask

  task automatic hijack_case(input int h);
    int a0;
    settle();
    to_boundary();
    len_next = 4; br_next = 0;
    a0 = gcyc + 1;
    irq_at = a0;
    nmi_at = a0 + 4 + h; nmi_w = 1;
    tick();
    len_next = 2;
    wait_sync();
    chk(obs_ir == 11'd0, "R7 irq injected before hijack test", obs_ir, 0);
    repeat (5) tick();
    chk(vec_sel == (exp_hijack(h) ? 2'd1 : 2'd0), "R11 hijack vector", vec_sel,
        exp_hijack(h) ? 1 : 0);
    wait_sync();
    chk((obs_ir == 11'd0) == exp_nmi_after(h), "R11 nmi after break", obs_ir,
        exp_nmi_after(h) ? 0 : 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int b, s;
    void'($urandom(32'h00C0FFEE));
    // R1 reset state and sequence
    repeat (3) begin
      tick();
      chk(sync == 1'b1 && ir == 11'd0, "R1 held in reset", {sync, ir}, {1'b1, 11'd0});
    end
    res_n = 1'b1;
    tick();
    chk(hw_brk == 1'b1 && vec_sel == 2'd2, "R1 reset break", {hw_brk, vec_sel}, {1'b1, 2'd2});
    chk(stack_rd_only == 1'b1, "R12 reset stack reads", stack_rd_only, 1);
    chk(ir[2:0] == 3'd1, "R2 count after fetch", ir[2:0], 1);
    wait_sync();
    chk(obs_ir == {obs_op, 3'b000} && obs_op != 8'h00, "R1 first opcode after reset",
        obs_ir, {obs_op, 3'b000});
    tick();
    chk(stack_rd_only == 1'b0 && hw_brk == 1'b0, "R12 normal instruction",
        {stack_rd_only, hw_brk}, 0);

    // R2 / R3 counter and fetch strobe on a long instruction
    settle();
    to_boundary();
    len_next = 10;
    tick();
    chk(sync == 1'b1 && ir[2:0] == 3'd0, "R3 sync after last", {sync, ir[2:0]}, {1'b1, 3'd0});
    for (int c = 1; c < 10; c++) begin
      tick();
      chk(ir[2:0] == ((c > 7) ? 3'd7 : 3'(c)), "R2 cycle count", ir[2:0], (c > 7) ? 7 : c);
      chk(sync == 1'b0, "R3 no sync mid-instruction", sync, 0);
    end
    len_next = 2;

    // R7 software break from the bus
    settle();
    to_boundary();
    opcode = 8'h00;
    tick();
    chk(obs_ir == 11'd0, "R7 bus break opcode", obs_ir, 0);
    tick();
    chk(hw_brk == 1'b0 && vec_sel == 2'd0, "R7 software break flags", {hw_brk, vec_sel}, 0);

    // R10 priority when both qualify
    settle();
    to_boundary();
    len_next = 4;
    irq_at = gcyc + 1; nmi_at = gcyc + 1; nmi_w = 1;
    tick();
    len_next = 2;
    wait_sync();
    chk(obs_ir == 11'd0, "R10 request injected", obs_ir, 0);
    tick();
    chk(vec_sel == 2'd1 && hw_brk == 1'b1, "R10 nmi wins", {hw_brk, vec_sel}, {1'b1, 2'd1});

    // R8 edge sensitivity
    settle();
    s = nmi_svc;
    nmi_at = gcyc + 1; nmi_w = 60;
    repeat (90) tick();
    chk(nmi_svc - s == 1, "R8 one service per edge", nmi_svc - s, 1);

    // R9 masking
    settle();
    i_flag = 1'b1;
    b = brk_cnt;
    irq_at = gcyc + 1;
    repeat (40) tick();
    chk(brk_cnt - b == 0, "R9 masked irq ignored", brk_cnt - b, 0);
    i_flag = 1'b0;
    repeat (20) tick();
    chk(brk_cnt - b == 1, "R9 unmasked irq serviced", brk_cnt - b, 1);

    // R4 R5 R6 directed edges of the windows
    window(1'b0, 5, 1'b0, 2);
    window(1'b0, 5, 1'b0, 3);
    window(1'b0, 5, 1'b1, 3);
    window(1'b0, 5, 1'b1, 4);
    window(1'b1, 2, 1'b0, 0);
    window(1'b1, 7, 1'b0, 4);

    // random windows
    for (int t = 0; t < 60; t++) begin
      int len, j;
      bit br, kind;
      len = 2 + int'($urandom % 6);
      j = int'($urandom % len);
      br = 1'($urandom % 2);
      kind = 1'($urandom % 2);
      window(kind, len, br, j);
    end

    // R11 hijack sweep
    for (int h = -1; h <= 6; h++) hijack_case(h);

    settle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule